// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a byte-wide, bus-addressed timer holding three independent 16-bit down-counters. They share one control port. A host programs a channel with a control byte. The byte picks the channel, how that channel's count is moved over the byte bus, a waveform mode and a BCD flag. The host then writes the count, one or two bytes at a time. It can freeze a running count and read it back in two halves, or fetch a status snapshot of the channel. Every channel has three single-bit pins:
- a count-tick strobe, one system clock wide, which stands in for the channel's clock input;
- a gate input;
- a waveform output.

A fourth per-channel pin flags an illegal count.

Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. A control byte carries four fields:
- bits 7:6 select the channel;
- bits 5:4 give the access mode: 00 latch command, 01 low byte only, 10 high byte only, 11 low byte then high byte;
- bits 3:1 give the waveform mode;
- bit 0 is the BCD flag.

When bits 7:6 equal 11, the byte is a read-back command instead. Bit 5 low latches the count and bit 4 low latches the status, for each channel n whose bit n+1 is set. The status byte holds, from bit 7 down: the output level, the null-count flag, the two access bits, the three mode bits and the BCD flag.

Each channel is a state machine with five states:
- CH_UNPROG: after reset, nothing written yet.
- CH_NEED_CNT: programmed, count not yet complete.
- CH_LOAD: count complete, waiting for the next tick to load it.
- CH_COUNT: running.
- CH_HALT: an illegal count was written.

The transitions are:
- program: any state goes to CH_NEED_CNT on a control byte for the channel.
- count-complete: goes to CH_LOAD, or to CH_HALT when the count is illegal.
- load-tick: CH_LOAD goes to CH_COUNT.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset every output and error pin is low, and reading any data port returns 0x00. A read-back status of any channel returns 0x00.
- R2: Addresses 0 to 2 reach channels 0 to 2, and address 3 is the write-only control port; reading address 3 returns 0x00.
- R3: A control byte with access bits other than 00 programs the selected channel. Programming sets null-count and clears the error pin. It drives the output low for modes 0, 1, 4 and 5, and high for modes 2, 3, 6 and 7.
- R4: Access 01 moves only the low byte and access 10 only the high byte, the other byte counting as zero. Each write completes the count, and each read returns that byte without advancing. Access 11 moves the low byte and then the high byte, alternating on every access.
- R5: A count takes effect only once its last byte is written. It is loaded on the next tick, and only then is null-count cleared. Ticks before that leave the output and the status unchanged.
- R6: A latch command (access bits 00) freezes the channel's count. The next reads return the frozen low byte and then the frozen high byte, while counting goes on. Later reads return the live count.
- R7: Control byte 0xE0 OR (2 shifted left by n) makes the next read of channel n return its status byte, once. The following read returns count data again.
- R8: A count of 0 acts as 65536: the first byte read after loading is 0x00, and one tick later the count reads 0xFFFF.
- R9: In mode 0, a count N gives an output that stays low and rises after the N-th gated tick following the load tick. It then stays high.
- R10: In mode 2, with count N ≥ 2, the output is high and goes low for exactly one tick period in every N. After k gated ticks from the load it is low exactly when k mod N equals N-1.
- R11: In mode 3, with count N ≥ 2, the output is a square wave of period N that is high for N - floor(N/2) ticks. After k gated ticks from the load it is low exactly when k mod N ≥ N - floor(N/2).
- R12: Ticks are counted only while the gate is high. In modes 2 and 3 a low gate forces the output high. After a gate rising edge, the next tick restarts the period from the loaded count.
- R13: Writing a count of 1 in mode 2 or 3 raises the error pin and drives the output high. The counter stays idle, its count unchanged by ticks, until it is reprogrammed or given a legal count.
- R14: Modes 1, 4 and 5 and the BCD flag are stored and reported in the status byte, and counting stays binary. Modes 1, 4 and 5 produce the mode 0 waveform, and modes 6 and 7 produce the mode 2 and mode 3 waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 to 2 data ports, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid while bus_rd is high |
| cnt_tick | input | 3 | Per-channel count strobe, one clock wide |
| cnt_gate | input | 3 | Per-channel gate |
| cnt_out | output | 3 | Per-channel waveform output |
| cnt_err | output | 3 | Per-channel illegal-count flag |

## Verification
Some rules are checked by the assertions on every cycle:
- an errored channel holds its output high and its count frozen;
- the count moves only on a tick, and never while the gate is low;
- a running channel never shows null-count;
- in mode 2 the output can be low only while the phase count is 1;
- a low gate forces the output high in the periodic modes;
- a control write programs at most one channel.

Other behaviour can be shown only by the bench's scenarios:
- the exact tick on which each waveform changes, over swept counts;
- the byte order of writes, latched reads and status reads;
- that 0 stands for 65536;
- the gate-edge restart.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_BYTE_W = 8;
    localparam int PIT_NUM_CH = 3;
    localparam int PIT_CNT_W  = 2 * PIT_BYTE_W;
    localparam int PIT_ADDR_W = 2;

    typedef enum logic [2:0] {
        CH_UNPROG,
        CH_NEED_CNT,
        CH_LOAD,
        CH_COUNT,
        CH_HALT
    } ch_state_t;

    typedef enum logic [1:0] {
        WAVE_TERM,
        WAVE_RATE,
        WAVE_SQUARE
    } wave_t;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LOW   = 2'b01,
        ACC_HIGH  = 2'b10,
        ACC_PAIR  = 2'b11
    } acc_t;

    // Modes x10 give the rate waveform, x11 the square wave, others one-shot terminal count.
    function automatic wave_t wave_of(input logic [2:0] mode);
        wave_t w;
        if (mode[1:0] == 2'b10)
            w = WAVE_RATE;
        else if (mode[1:0] == 2'b11)
            w = WAVE_SQUARE;
        else
            w = WAVE_TERM;
        return w;
    endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = PIT_NUM_CH,
    parameter int BYTE_W = PIT_BYTE_W
) (
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output logic [NUM_CH-1:0] prog,
    output logic [NUM_CH-1:0] cnt_latch,
    output logic [NUM_CH-1:0] sts_latch,
    output acc_t              cfg_acc,
    output logic [2:0]        cfg_mode,
    output logic              cfg_bcd
);

    logic [1:0] sel;
    logic       is_readback;

    assign sel         = ctrl_byte[7:6];
    assign is_readback = (sel == 2'b11);
    assign cfg_acc     = acc_t'(ctrl_byte[5:4]);
    assign cfg_mode    = ctrl_byte[3:1];
    assign cfg_bcd     = ctrl_byte[0];

    always_comb begin
        prog      = '0;
        cnt_latch = '0;
        sts_latch = '0;
        if (ctrl_wr) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (is_readback) begin
                    // read-back: bit n+1 selects channel n, bits 5 and 4 are active low
                    if (ctrl_byte[n+1]) begin
                        cnt_latch[n] = ~ctrl_byte[5];
                        sts_latch[n] = ~ctrl_byte[4];
                    end
                end else if (sel == 2'(n)) begin
                    if (ctrl_byte[5:4] == 2'b00)
                        cnt_latch[n] = 1'b1;
                    else
                        prog[n] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W = PIT_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  acc_t              cfg_acc,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_bcd,
    input  logic              cnt_latch,
    input  logic              sts_latch,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  logic              gate,
    output logic [BYTE_W-1:0] rdata,
    output logic              out,
    output logic              err
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam int CE_W  = CNT_W + 1;

    ch_state_t         state_q, state_d;
    acc_t              acc_q;
    logic [2:0]        mode_q;
    logic              bcd_q;
    logic [BYTE_W-1:0] lo_q;
    logic [CNT_W-1:0]  n_q;
    logic              wr_hi_q, rd_hi_q;
    logic [CE_W-1:0]   ce_q;
    logic              out_q, null_q, err_q;
    logic              lat_v_q, sts_v_q;
    logic [CNT_W-1:0]  lat_q;
    logic [BYTE_W-1:0] sts_q;
    logic              gate_q, reload_q;

    wave_t             wave;
    logic              wr_done, bad_cnt, gate_rise, sel_hi;
    logic [CNT_W-1:0]  wr_val;
    logic [CE_W-1:0]   n_ext, half, high_len, low_len;
    logic [BYTE_W-1:0] status_now;

    assign wave       = wave_of(mode_q);
    assign gate_rise  = gate && !gate_q;
    assign status_now = {out_q, null_q, acc_q, mode_q, bcd_q};

    // count write sequencing
    always_comb begin
        wr_done = 1'b0;
        wr_val  = n_q;
        if (port_wr && state_q != CH_UNPROG) begin
            unique case (acc_q)
                ACC_LOW: begin
                    wr_done = 1'b1;
                    wr_val  = {{BYTE_W{1'b0}}, wdata};
                end
                ACC_HIGH: begin
                    wr_done = 1'b1;
                    wr_val  = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_PAIR: begin
                    wr_done = wr_hi_q;
                    wr_val  = {wdata, lo_q};
                end
                ACC_LATCH: begin
                    wr_done = 1'b0;
                end
            endcase
        end
    end

    assign bad_cnt = wr_done && (wave != WAVE_TERM) && (wr_val == CNT_W'(1));

    // phase lengths; a zero count means the full 2^CNT_W
    assign n_ext = (n_q == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n_q};
    assign half  = n_ext >> 1;

    always_comb begin
        unique case (wave)
            WAVE_RATE: begin
                high_len = n_ext - CE_W'(1);
                low_len  = CE_W'(1);
            end
            WAVE_SQUARE: begin
                high_len = n_ext - half;
                low_len  = half;
            end
            default: begin
                high_len = n_ext;
                low_len  = n_ext;
            end
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (prog)
            state_d = CH_NEED_CNT;
        else if (wr_done)
            state_d = bad_cnt ? CH_HALT : CH_LOAD;
        else begin
            unique case (state_q)
                CH_LOAD:     if (tick) state_d = CH_COUNT;
                CH_UNPROG,
                CH_NEED_CNT,
                CH_COUNT,
                CH_HALT:     state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_UNPROG;
        else
            state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= ACC_LATCH;
            mode_q   <= 3'd0;
            bcd_q    <= 1'b0;
            lo_q     <= '0;
            n_q      <= '0;
            wr_hi_q  <= 1'b0;
            rd_hi_q  <= 1'b0;
            ce_q     <= '0;
            out_q    <= 1'b0;
            null_q   <= 1'b0;
            err_q    <= 1'b0;
            lat_v_q  <= 1'b0;
            lat_q    <= '0;
            sts_v_q  <= 1'b0;
            sts_q    <= '0;
            gate_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (prog) begin
                acc_q    <= cfg_acc;
                mode_q   <= cfg_mode;
                bcd_q    <= cfg_bcd;
                wr_hi_q  <= 1'b0;
                rd_hi_q  <= 1'b0;
                lat_v_q  <= 1'b0;
                sts_v_q  <= 1'b0;
                null_q   <= 1'b1;
                err_q    <= 1'b0;
                reload_q <= 1'b0;
                out_q    <= (wave_of(cfg_mode) != WAVE_TERM);
            end else begin
                if (port_wr && state_q != CH_UNPROG && acc_q == ACC_PAIR) begin
                    wr_hi_q <= ~wr_hi_q;
                    if (!wr_hi_q)
                        lo_q <= wdata;
                end
                if (wr_done) begin
                    n_q    <= wr_val;
                    null_q <= 1'b1;
                    if (bad_cnt) begin
                        err_q <= 1'b1;
                        out_q <= 1'b1;
                    end else begin
                        err_q <= 1'b0;
                        if (wave == WAVE_TERM)
                            out_q <= 1'b0;
                    end
                end else if (state_q == CH_LOAD && tick) begin
                    ce_q     <= high_len;
                    out_q    <= (wave != WAVE_TERM);
                    null_q   <= 1'b0;
                    reload_q <= 1'b0;
                end else if (state_q == CH_COUNT) begin
                    if (gate_rise && wave != WAVE_TERM)
                        reload_q <= 1'b1;
                    if (!gate) begin
                        if (wave != WAVE_TERM)
                            out_q <= 1'b1;
                    end else if (tick) begin
                        if (reload_q && wave != WAVE_TERM) begin
                            ce_q     <= high_len;
                            out_q    <= 1'b1;
                            reload_q <= 1'b0;
                        end else if (wave == WAVE_TERM) begin
                            ce_q <= ce_q - CE_W'(1);
                            if (ce_q == CE_W'(1))
                                out_q <= 1'b1;
                        end else if (ce_q == CE_W'(1)) begin
                            out_q <= ~out_q;
                            ce_q  <= out_q ? low_len : high_len;
                        end else begin
                            ce_q <= ce_q - CE_W'(1);
                        end
                    end
                end
                if (cnt_latch && !lat_v_q && state_q != CH_UNPROG) begin
                    lat_v_q <= 1'b1;
                    lat_q   <= ce_q[CNT_W-1:0];
                end
                if (sts_latch && !sts_v_q) begin
                    sts_v_q <= 1'b1;
                    sts_q   <= status_now;
                end
                if (port_rd) begin
                    if (sts_v_q) begin
                        sts_v_q <= 1'b0;
                    end else begin
                        if (acc_q == ACC_PAIR)
                            rd_hi_q <= ~rd_hi_q;
                        if (lat_v_q && (acc_q != ACC_PAIR || rd_hi_q))
                            lat_v_q <= 1'b0;
                    end
                end
            end
        end
    end

    // read data
    assign sel_hi = (acc_q == ACC_HIGH) || (acc_q == ACC_PAIR && rd_hi_q);

    always_comb begin
        if (sts_v_q)
            rdata = sts_q;
        else if (lat_v_q)
            rdata = sel_hi ? lat_q[CNT_W-1:BYTE_W] : lat_q[BYTE_W-1:0];
        else
            rdata = sel_hi ? ce_q[CNT_W-1:BYTE_W] : ce_q[BYTE_W-1:0];
    end

    assign out = out_q;
    assign err = err_q;

    // R13
    err_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> out_q);

    // R13
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT) |=> $stable(ce_q));

    // R12
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ce_q));

    // R12
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !gate) |=> $stable(ce_q));

    // R12
    gate_low_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !gate && wave != WAVE_TERM && !prog) |=> out_q);

    // R5
    null_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT) |-> !null_q);

    // R10
    rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && wave == WAVE_RATE && !out_q) |-> (ce_q == CE_W'(1)));

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
    import pit_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIT_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [PIT_BYTE_W-1:0] bus_wdata,
    output logic [PIT_BYTE_W-1:0] bus_rdata,
    input  logic [PIT_NUM_CH-1:0] cnt_tick,
    input  logic [PIT_NUM_CH-1:0] cnt_gate,
    output logic [PIT_NUM_CH-1:0] cnt_out,
    output logic [PIT_NUM_CH-1:0] cnt_err
);

    localparam logic [PIT_ADDR_W-1:0] CTRL_ADDR = PIT_ADDR_W'(PIT_NUM_CH);

    logic                  ctrl_wr;
    logic [PIT_NUM_CH-1:0] dec_prog, dec_cnt_latch, dec_sts_latch;
    acc_t                  dec_acc;
    logic [2:0]            dec_mode;
    logic                  dec_bcd;
    logic [PIT_BYTE_W-1:0] ch_rdata [PIT_NUM_CH];

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

    pit_ctrl_decode #(
        .NUM_CH (PIT_NUM_CH),
        .BYTE_W (PIT_BYTE_W)
    ) u_decode (
        .ctrl_wr   (ctrl_wr),
        .ctrl_byte (bus_wdata),
        .prog      (dec_prog),
        .cnt_latch (dec_cnt_latch),
        .sts_latch (dec_sts_latch),
        .cfg_acc   (dec_acc),
        .cfg_mode  (dec_mode),
        .cfg_bcd   (dec_bcd)
    );

    for (genvar g = 0; g < PIT_NUM_CH; g++) begin : g_ch
        pit_channel #(
            .BYTE_W (PIT_BYTE_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (dec_prog[g]),
            .cfg_acc   (dec_acc),
            .cfg_mode  (dec_mode),
            .cfg_bcd   (dec_bcd),
            .cnt_latch (dec_cnt_latch[g]),
            .sts_latch (dec_sts_latch[g]),
            .port_wr   (bus_wr && (bus_addr == PIT_ADDR_W'(g))),
            .port_rd   (bus_rd && (bus_addr == PIT_ADDR_W'(g))),
            .wdata     (bus_wdata),
            .tick      (cnt_tick[g]),
            .gate      (cnt_gate[g]),
            .rdata     (ch_rdata[g]),
            .out       (cnt_out[g]),
            .err       (cnt_err[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int i = 0; i < PIT_NUM_CH; i++) begin
                if (bus_addr == PIT_ADDR_W'(i))
                    bus_rdata = ch_rdata[i];
            end
        end
    end

    // R3
    ctrl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_prog));

endmodule

// File: tb/test_prog_interval_timer.sv
module test_prog_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] cnt_tick = '0;
    logic [2:0] cnt_gate = 3'b111;
    logic [2:0] cnt_out;
    logic [2:0] cnt_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    prog_interval_timer i_prog_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .cnt_gate  (cnt_gate),
        .cnt_out   (cnt_out),
        .cnt_err   (cnt_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(input logic [1:0] a, output int v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a, hi);
        v = {16'h0, hi, lo};
    endtask

    task automatic tk(input logic [2:0] m);
        @(negedge clk);
        cnt_tick = m;
        @(negedge clk);
        cnt_tick = '0;
    endtask

    task automatic load16(input logic [1:0] a, input int n);
        wr(a, n[7:0]);
        wr(a, n[15:8]);
    endtask

    task automatic status(input int ch, output logic [7:0] s);
        wr(2'd3, 8'hE0 | (8'd2 << ch));
        rd(2'(ch), s);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int v, v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out", int'(cnt_out), 0);
        chk("R1 err", int'(cnt_err), 0);
        for (int ch = 0; ch < 3; ch++) begin
            rd(2'(ch), b);
            chk("R1 count", int'(b), 0);
            status(ch, b);
            chk("R1 status", int'(b), 0);
        end
        // R2 control port reads zero
        rd(2'd3, b);
        chk("R2 ctrl read", int'(b), 0);

        // R9 / R5 / R3 mode 0 sweep over channels and counts
        for (int ch = 0; ch < 3; ch++) begin
            for (int n = 1; n <= 5; n++) begin
                wr(2'd3, {2'(ch), 2'b11, 3'd0, 1'b0});
                chk("R3 mode0 out low", int'(cnt_out[ch]), 0);
                load16(2'(ch), n);
                status(ch, b);
                chk("R5 null before load", int'(b), 8'h70);
                tk(3'(1 << ch));
                status(ch, b);
                chk("R5 null after load", int'(b), 8'h30);
                for (int k = 1; k <= n + 2; k++) begin
                    tk(3'(1 << ch));
                    chk("R9 mode0 out", int'(cnt_out[ch]), (k >= n) ? 1 : 0);
                end
            end
        end

        // R5 half-written count has no effect
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h03);
        for (int k = 0; k < 4; k++) tk(3'b001);
        chk("R5 partial out", int'(cnt_out[0]), 0);
        status(0, b);
        chk("R5 partial status", int'(b), 8'h70);
        wr(2'd0, 8'h00);
        tk(3'b001);
        for (int k = 1; k <= 3; k++) tk(3'b001);
        chk("R5 after high byte", int'(cnt_out[0]), 1);

        // R10 / R11 periodic sweep on channel 0
        for (int m = 2; m <= 3; m++) begin
            for (int n = 2; n <= 7; n++) begin
                int hl;
                string rq;
                rq = (m == 2) ? "R10" : "R11";
                hl = (m == 2) ? n - 1 : n - n / 2;
                wr(2'd3, {2'd0, 2'b11, 3'(m), 1'b0});
                chk({rq, " initial high"}, int'(cnt_out[0]), 1);
                load16(2'd0, n);
                tk(3'b001);
                for (int k = 1; k <= 2 * n; k++) begin
                    tk(3'b001);
                    chk({rq, " wave"}, int'(cnt_out[0]), ((k % n) >= hl) ? 0 : 1);
                end
            end
        end

        // R13 illegal count
        wr(2'd3, 8'h00);
        rd16(2'd0, v0);
        wr(2'd3, 8'h34);
        load16(2'd0, 1);
        chk("R13 err mode2", int'(cnt_err[0]), 1);
        chk("R13 out high", int'(cnt_out[0]), 1);
        for (int k = 0; k < 3; k++) tk(3'b001);
        wr(2'd3, 8'h00);
        rd16(2'd0, v);
        chk("R13 count frozen", v, v0);
        wr(2'd3, 8'h36);
        chk("R3 err cleared", int'(cnt_err[0]), 0);
        load16(2'd0, 1);
        chk("R13 err mode3", int'(cnt_err[0]), 1);
        wr(2'd3, 8'h30);
        load16(2'd0, 1);
        chk("R13 mode0 count1 legal", int'(cnt_err[0]), 0);

        // R6 latch on channel 1, then R7 status once
        wr(2'd3, 8'h70);
        load16(2'd1, 300);
        tk(3'b010);
        for (int k = 0; k < 5; k++) tk(3'b010);
        wr(2'd3, 8'h40);
        for (int k = 0; k < 3; k++) tk(3'b010);
        rd16(2'd1, v);
        chk("R6 latched", v, 295);
        rd16(2'd1, v);
        chk("R6 live", v, 292);
        status(1, b);
        chk("R7 status", int'(b), 8'h30);
        rd(2'd1, b);
        chk("R7 next read is count", int'(b), 8'h24);
        rd(2'd1, b);

        // R12 gate on channel 1, mode 2, count 4
        wr(2'd3, 8'h74);
        load16(2'd1, 4);
        tk(3'b010);
        tk(3'b010);
        tk(3'b010);
        @(negedge clk);
        cnt_gate[1] = 1'b0;
        @(negedge clk);
        chk("R12 gate low out", int'(cnt_out[1]), 1);
        for (int k = 0; k < 3; k++) tk(3'b010);
        chk("R12 gate low out held", int'(cnt_out[1]), 1);
        wr(2'd3, 8'h40);
        rd16(2'd1, v);
        chk("R12 count held", v, 1);
        cnt_gate[1] = 1'b1;
        @(negedge clk);
        tk(3'b010);
        tk(3'b010);
        tk(3'b010);
        chk("R12 restart k2", int'(cnt_out[1]), 1);
        tk(3'b010);
        chk("R12 restart k3", int'(cnt_out[1]), 0);
        cnt_gate[1] = 1'b0;
        @(negedge clk);
        chk("R12 gate forces high", int'(cnt_out[1]), 1);
        cnt_gate[1] = 1'b1;
        @(negedge clk);

        // R8 zero means 65536
        wr(2'd3, 8'hB0);
        load16(2'd2, 0);
        tk(3'b100);
        wr(2'd3, 8'h80);
        rd16(2'd2, v);
        chk("R8 loaded", v, 0);
        tk(3'b100);
        wr(2'd3, 8'h80);
        rd16(2'd2, v);
        chk("R8 after one", v, 16'hFFFF);
        chk("R8 out low", int'(cnt_out[2]), 0);

        // R14 stored modes and BCD flag
        wr(2'd3, 8'hBB);
        status(2, b);
        chk("R14 status mode5 bcd", int'(b), 8'h7B);
        wr(2'd3, 8'hBC);
        chk("R14 mode6 high", int'(cnt_out[2]), 1);
        load16(2'd2, 3);
        tk(3'b100);
        for (int k = 1; k <= 6; k++) begin
            tk(3'b100);
            chk("R14 mode6 as rate", int'(cnt_out[2]), ((k % 3) >= 2) ? 0 : 1);
        end

        // R4 single-byte access modes on channel 0
        wr(2'd3, 8'h10);
        wr(2'd0, 8'h05);
        tk(3'b001);
        rd(2'd0, b);
        chk("R4 low only", int'(b), 5);
        rd(2'd0, b);
        chk("R4 low only again", int'(b), 5);
        for (int k = 1; k <= 4; k++) tk(3'b001);
        chk("R4 mode0 k4", int'(cnt_out[0]), 0);
        tk(3'b001);
        chk("R4 mode0 k5", int'(cnt_out[0]), 1);
        wr(2'd3, 8'h20);
        wr(2'd0, 8'h01);
        tk(3'b001);
        rd(2'd0, b);
        chk("R4 high only", int'(b), 1);
        tk(3'b001);
        rd(2'd0, b);
        chk("R4 high after tick", int'(b), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule